// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. It has two stages. A holding register takes a character from a parallel bus while an active-low load strobe is low. A shift stage then sends the character as a frame: a low start bit, five to eight data bits with the least significant bit first, an optional parity bit, and one, one and a half, or two high stop bits. Every bit time is a fixed number of pulses of a clock-enable input, `tick`, which runs at sixteen times the bit rate.

The rising edge of the load strobe asks for the held character to move into the shift stage. If a frame is still going out, the request waits until that frame's last stop tick. The queued character then starts on the very next tick, so the two frames leave with no idle time between them. Two flags report the state of each stage. A master reset abandons any frame, empties the holding register and returns the line to idle. The line is reported empty only after a fixed number of clocks once reset is released.

Top module: `dbtx_top`

## Requirements
- R1: While `mr` is high, the block holds `txd` high, `buf_empty` high and `tx_empty` low from the clock edge after `mr` is sampled high.
- R2: After `mr` falls, `tx_empty` stays low through the first 17 rising clock edges that sample `mr` low, and it is high after the 18th. No frame starts before that point.
- R3: Every clock edge that samples `load_n` low writes `din` into the holding register and makes `buf_empty` low after that edge.
- R4: An edge that samples `load_n` high, with `load_n` low on the edge before it, requests a transfer. The request is served on the first later edge at which the shift stage can accept a character.
- R5: Each frame is a start bit held low for 16 ticks, then data bits sent least significant bit first for 16 ticks each, then an optional parity bit of 16 ticks, then high stop bits. The line rests high between frames.
- R6: `len_sel` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `din` above the selected length have no effect on the frame.
- R7: When `par_off` is high, no parity bit is sent. When it is low, a parity bit follows the data. It makes the count of ones even when `par_even` is 1 and odd when `par_even` is 0.
- R8: With `stop_sel` low, the stop period is 16 ticks. With `stop_sel` high, it is 24 ticks for 5-bit characters and 32 ticks for 6- to 8-bit characters.
- R9: A character loaded while a frame is being sent is held with `buf_empty` low. Its start bit begins on the tick right after the last stop tick of the current frame.
- R10: `buf_empty` goes high on the edge that moves a character into the shift stage. `tx_empty` is low from that edge until the last stop tick of the last queued frame.
- R11: Asserting `mr` in the middle of a frame drops that frame and any pending transfer. After reset is released, no leftover character is sent.
- R12: The format fields are captured when a transfer happens. Changing them while a frame is being sent does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mr | input | 1 | Master reset, synchronous, active high |
| tick | input | 1 | Clock enable at sixteen times the bit rate |
| load_n | input | 1 | Active-low load strobe for the holding register |
| din | input | DATA_W | Parallel character input |
| len_sel | input | 2 | Data length select (00=5 … 11=8 bits) |
| stop_sel | input | 1 | Selects the longer stop period |
| par_off | input | 1 | High leaves out the parity bit |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding register free for a new character |
| tx_empty | output | 1 | Shift stage idle and line quiet |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, 16 ticks per bit and an 18-clock release delay after reset. It drives `tick` on every second clock. With these values, each stop length (16, 24 and 32 ticks) and each combination of data length and parity appears in a frame of a few hundred clocks. The 18-edge release window can be checked edge by edge. The same settings make room for a queued character to follow a frame directly and for a reset to arrive in the middle of a frame that has a transfer pending.

// File: rtl/dbtx_pkg.sv
`timescale 1ns/1ps
package dbtx_pkg;

    typedef enum logic [1:0] {
        LEN5 = 2'b00,
        LEN6 = 2'b01,
        LEN7 = 2'b10,
        LEN8 = 2'b11
    } len_e;

    typedef struct packed {
        len_e len;
        logic stop_long;
        logic par_off;
        logic par_even;
    } fmt_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    // number of data bits carried by a length code
    function automatic int unsigned data_bits(input len_e l);
        return 32'd5 + 32'(l);
    endfunction

    // length of the stop period in ticks
    function automatic int unsigned stop_ticks(input fmt_t f, input int unsigned tpb);
        if (!f.stop_long)
            return tpb;
        else if (f.len == LEN5)
            return tpb + tpb / 2;
        else
            return 2 * tpb;
    endfunction

endpackage

// File: rtl/dbtx_init_timer.sv
`timescale 1ns/1ps
module dbtx_init_timer #(
    parameter int unsigned DELAY = 18
) (
    input  logic clk,
    input  logic mr,
    output logic ready
);
    localparam int unsigned CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt_q;
    logic          ready_q;

    always_ff @(posedge clk) begin
        if (mr) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(DELAY - 1))
                ready_q <= 1'b1;
        end
    end

    assign ready = ready_q;
endmodule

// File: rtl/dbtx_holding.sv
`timescale 1ns/1ps
module dbtx_holding #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              mr,
    input  logic              load_n,
    input  logic [DATA_W-1:0] din,
    input  logic              take,
    output logic [DATA_W-1:0] held,
    output logic              xfer,
    output logic              empty
);
    logic              strobe_q;
    logic              pend_q;
    logic              empty_q;
    logic [DATA_W-1:0] data_q;
    logic              rise;

    assign rise = load_n && !strobe_q;
    assign xfer = pend_q && take;

    always_ff @(posedge clk) begin
        if (mr) begin
            strobe_q <= 1'b1;
            pend_q   <= 1'b0;
            empty_q  <= 1'b1;
        end else begin
            strobe_q <= load_n;
            if (xfer) begin
                pend_q  <= 1'b0;
                empty_q <= 1'b1;
            end
            if (rise)
                pend_q <= 1'b1;
            if (!load_n)
                empty_q <= 1'b0;
        end
    end

    // the character itself survives reset
    always_ff @(posedge clk) begin
        if (!mr && !load_n)
            data_q <= din;
    end

    assign held  = data_q;
    assign empty = empty_q;
endmodule

// File: rtl/dbtx_shifter.sv
`timescale 1ns/1ps
module dbtx_shifter
    import dbtx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TPB    = 16
) (
    input  logic              clk,
    input  logic              mr,
    input  logic              tick,
    input  logic              ready,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  fmt_t              fmt,
    output logic              txd,
    output logic              can_take,
    output logic              idle
);
    localparam int unsigned CW = $clog2(2 * TPB);
    localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    phase_e            ph_q;
    logic [CW-1:0]     tcnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              par_q;
    fmt_t              fmt_q;

    logic [DATA_W-1:0] masked;
    logic              bit_end;
    logic              stop_end;
    logic [BW-1:0]     last_bit;
    logic [CW-1:0]     stop_last;

    // clear the data bits above the selected length
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            masked[i] = data[i] && (i < int'(data_bits(fmt.len)));
    end

    assign last_bit  = BW'(data_bits(fmt_q.len) - 1);
    assign stop_last = CW'(stop_ticks(fmt_q, TPB) - 1);
    assign bit_end   = tick && (tcnt_q == CW'(TPB - 1));
    assign stop_end  = (ph_q == PH_STOP) && tick && (tcnt_q == stop_last);

    assign idle     = (ph_q == PH_IDLE);
    assign can_take = ready && (idle || stop_end);

    always_ff @(posedge clk) begin
        if (mr) begin
            ph_q   <= PH_IDLE;
            tcnt_q <= '0;
            bit_q  <= '0;
        end else if (start) begin
            ph_q   <= PH_START;
            tcnt_q <= '0;
            bit_q  <= '0;
            sh_q   <= masked;
            fmt_q  <= fmt;
            par_q  <= fmt.par_even ? (^masked) : ~(^masked);
        end else if (tick) begin
            unique case (ph_q)
                PH_START: begin
                    if (bit_end) begin
                        ph_q   <= PH_DATA;
                        tcnt_q <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (bit_end) begin
                        tcnt_q <= '0;
                        sh_q   <= sh_q >> 1;
                        if (bit_q == last_bit)
                            ph_q <= fmt_q.par_off ? PH_STOP : PH_PAR;
                        else
                            bit_q <= bit_q + 1'b1;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                PH_PAR: begin
                    if (bit_end) begin
                        ph_q   <= PH_STOP;
                        tcnt_q <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                PH_STOP: begin
                    if (stop_end) begin
                        ph_q   <= PH_IDLE;
                        tcnt_q <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: tcnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        unique case (ph_q)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = sh_q[0];
            PH_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbtx_top.sv
`timescale 1ns/1ps
module dbtx_top
    import dbtx_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned TPB        = 16,
    parameter int unsigned INIT_DELAY = 18
) (
    input  logic              clk,
    input  logic              mr,
    input  logic              tick,
    input  logic              load_n,
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        len_sel,
    input  logic              stop_sel,
    input  logic              par_off,
    input  logic              par_even,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_empty
);
    logic              ready;
    logic              take;
    logic              xfer;
    logic              sh_idle;
    logic [DATA_W-1:0] held;
    fmt_t              fmt;

    assign fmt.len       = len_e'(len_sel);
    assign fmt.stop_long = stop_sel;
    assign fmt.par_off   = par_off;
    assign fmt.par_even  = par_even;

    dbtx_init_timer #(.DELAY(INIT_DELAY)) u_timer (
        .clk   (clk),
        .mr    (mr),
        .ready (ready)
    );

    dbtx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .mr     (mr),
        .load_n (load_n),
        .din    (din),
        .take   (take),
        .held   (held),
        .xfer   (xfer),
        .empty  (buf_empty)
    );

    dbtx_shifter #(.DATA_W(DATA_W), .TPB(TPB)) u_shift (
        .clk      (clk),
        .mr       (mr),
        .tick     (tick),
        .ready    (ready),
        .start    (xfer),
        .data     (held),
        .fmt      (fmt),
        .txd      (txd),
        .can_take (take),
        .idle     (sh_idle)
    );

    assign tx_empty = ready && sh_idle;
endmodule

// File: rtl/dbtx_checker.sv
`timescale 1ns/1ps
module dbtx_checker #(
    parameter int unsigned INIT_DELAY = 18
) (
    input logic clk,
    input logic mr,
    input logic load_n,
    input logic txd,
    input logic buf_empty,
    input logic tx_empty
);
    localparam int unsigned CW = $clog2(INIT_DELAY + 1);

    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (mr)
            since_rst <= '0;
        else if (since_rst < CW'(INIT_DELAY))
            since_rst <= since_rst + 1'b1;
    end

    a_r1_reset_outputs: assert property (@(posedge clk) disable iff (mr)
        $past(mr) |-> (txd && buf_empty && !tx_empty));

    a_r2_no_early_empty: assert property (@(posedge clk) disable iff (mr)
        (since_rst < CW'(INIT_DELAY)) |-> (!tx_empty && txd));

    a_r3_load_marks_full: assert property (@(posedge clk) disable iff (mr)
        !load_n |=> !buf_empty);

    a_r10_busy_when_low: assert property (@(posedge clk) disable iff (mr)
        !txd |-> !tx_empty);

    a_r5_idle_line_high: assert property (@(posedge clk) disable iff (mr)
        tx_empty |-> txd);
endmodule

bind dbtx_top dbtx_checker #(.INIT_DELAY(INIT_DELAY)) u_chk (
    .clk       (clk),
    .mr        (mr),
    .load_n    (load_n),
    .txd       (txd),
    .buf_empty (buf_empty),
    .tx_empty  (tx_empty)
);

// File: tb/dbtx_top_tb.sv
`timescale 1ns/1ps
module dbtx_top_tb;
    localparam int DATA_W = 8;
    localparam int TPB    = 16;

    typedef struct {
        logic [255:0] pat;
        int           len;
        bit           b2b;
        string        tag;
    } frame_t;

    logic              clk = 1'b0;
    logic              mr = 1'b1;
    logic              tick = 1'b0;
    logic              load_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic [1:0]        len_sel = 2'b11;
    logic              stop_sel = 1'b0;
    logic              par_off = 1'b1;
    logic              par_even = 1'b0;
    logic              txd, buf_empty, tx_empty;

    int     nvec = 0;
    int     nfail = 0;
    frame_t exp_q[$];
    frame_t cur;
    int     idx = 0;
    bit     mon_active = 0;
    bit     b2b_due = 0;
    bit     frame_bad = 0;

    dbtx_top u_dut (
        .clk(clk), .mr(mr), .tick(tick), .load_n(load_n), .din(din),
        .len_sel(len_sel), .stop_sel(stop_sel), .par_off(par_off),
        .par_even(par_even), .txd(txd), .buf_empty(buf_empty), .tx_empty(tx_empty)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #1200000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // expected tick-by-tick picture of a frame (R5..R8)
    function automatic frame_t build(input logic [7:0] d, input logic [1:0] ls,
                                     input logic ss, input logic po, input logic pe,
                                     input bit b2b, input string tag);
        frame_t f;
        int nb = 5 + int'(ls);
        logic [7:0] m = '0;
        logic p;
        int stp;
        f.pat = '0; f.len = 0; f.b2b = b2b; f.tag = tag;
        for (int i = 0; i < nb; i++) m[i] = d[i];
        p = pe ? ($countones(m) % 2 == 1) : ($countones(m) % 2 == 0);
        for (int k = 0; k < TPB; k++) begin f.pat[f.len] = 1'b0; f.len++; end
        for (int i = 0; i < nb; i++)
            for (int k = 0; k < TPB; k++) begin f.pat[f.len] = m[i]; f.len++; end
        if (!po)
            for (int k = 0; k < TPB; k++) begin f.pat[f.len] = p; f.len++; end
        stp = !ss ? TPB : (nb == 5 ? TPB + TPB / 2 : 2 * TPB);
        for (int k = 0; k < stp; k++) begin f.pat[f.len] = 1'b1; f.len++; end
        return f;
    endfunction

    // monitor: compares the line against queued frames, one sample per tick
    initial begin
        forever begin
            @(negedge clk); #1;
            if (mr) begin
                mon_active = 0;
                b2b_due = 0;
            end else begin
                if (mon_active && tx_empty && !frame_bad) begin
                    frame_bad = 1;
                    $display("FAIL R10 %s: actual tx_empty 1 expected 0 mid-frame", cur.tag);
                end
                if (tick) begin
                    if (!mon_active) begin
                        if (b2b_due) begin
                            b2b_due = 0;
                            check(txd === 1'b0, "R9 no gap before queued start", int'(txd), 0);
                        end
                        if (txd === 1'b0) begin
                            if (exp_q.size() == 0) begin
                                check(0, "R11/R5 unexpected start bit", 0, 1);
                            end else begin
                                cur = exp_q.pop_front();
                                idx = 0;
                                mon_active = 1;
                                frame_bad = 0;
                            end
                        end
                    end
                    if (mon_active) begin
                        if (txd !== cur.pat[idx] && !frame_bad) begin
                            frame_bad = 1;
                            $display("FAIL %s: tick %0d actual %0d expected %0d",
                                     cur.tag, idx, txd, cur.pat[idx]);
                        end
                        idx++;
                        if (idx == cur.len) begin
                            nvec++;
                            if (frame_bad) nfail++;
                            mon_active = 0;
                            b2b_due = cur.b2b;
                        end
                    end
                end
            end
        end
    end

    task automatic set_fmt(input logic [1:0] ls, input logic ss, input logic po, input logic pe);
        @(negedge clk);
        len_sel = ls; stop_sel = ss; par_off = po; par_even = pe;
    endtask

    // driver: pushes the expected frame and pulses the strobe
    task automatic send(input logic [7:0] d, input bit b2b, input string tag);
        exp_q.push_back(build(d, len_sel, stop_sel, par_off, par_even, b2b, tag));
        @(negedge clk);
        din = d; load_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        load_n = 1'b1;
    endtask

    task automatic wait_busy();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!tx_empty) break;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); #2;
            if (tx_empty && exp_q.size() == 0 && !mon_active && !b2b_due) break;
        end
    endtask

    initial begin
        for (int i = 0; i < 5; i++) @(negedge clk);
        #2;
        check(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
        check(buf_empty === 1'b1, "R1 buf_empty in reset", int'(buf_empty), 1);
        check(tx_empty === 1'b0, "R1 tx_empty in reset", int'(tx_empty), 0);

        // R2: release window counted edge by edge
        @(negedge clk); mr = 1'b0;
        for (int i = 0; i < 17; i++) @(posedge clk);
        @(negedge clk); #2;
        check(tx_empty === 1'b0, "R2 tx_empty after 17 edges", int'(tx_empty), 0);
        @(posedge clk); @(negedge clk); #2;
        check(tx_empty === 1'b1, "R2 tx_empty after 18 edges", int'(tx_empty), 1);

        // R3/R4/R10: single 8-bit frame, no parity, one stop
        set_fmt(2'b11, 1'b0, 1'b1, 1'b0);
        exp_q.push_back(build(8'hA5, 2'b11, 1'b0, 1'b1, 1'b0, 0, "R5 8N1 A5"));
        @(negedge clk); din = 8'hA5; load_n = 1'b0;
        @(negedge clk); #2;
        check(buf_empty === 1'b0, "R3 buf_empty while loading", int'(buf_empty), 0);
        load_n = 1'b1;
        @(negedge clk); @(negedge clk); #2;
        check(buf_empty === 1'b1, "R10 buf_empty after transfer", int'(buf_empty), 1);
        check(tx_empty === 1'b0, "R4 tx_empty after transfer", int'(tx_empty), 0);
        wait_idle();

        // R6: 5-bit, upper bits driven high; R8 1.5 stop
        set_fmt(2'b00, 1'b1, 1'b1, 1'b0);
        send(8'hF6, 0, "R6/R8 5-bit 1.5 stop");
        wait_idle();
        // R7 even parity, 6-bit, R8 two stops
        set_fmt(2'b01, 1'b1, 1'b0, 1'b1);
        send(8'hEB, 0, "R7 6-bit even parity two stops");
        wait_idle();
        // R7 odd parity, 7-bit
        set_fmt(2'b10, 1'b0, 1'b0, 1'b0);
        send(8'hD3, 0, "R7 7-bit odd parity");
        wait_idle();
        // 8-bit even parity, two stops
        set_fmt(2'b11, 1'b1, 1'b0, 1'b1);
        send(8'h3C, 0, "R8 8-bit even parity two stops");
        wait_idle();
        // 5-bit odd parity one stop
        set_fmt(2'b00, 1'b0, 1'b0, 1'b0);
        send(8'hE0, 0, "R6 5-bit odd parity");
        wait_idle();

        // R9: queued second character follows with no gap
        set_fmt(2'b10, 1'b1, 1'b0, 1'b1);
        send(8'h55, 1, "R9 first of pair");
        wait_busy();
        send(8'h2A, 0, "R9 second of pair");
        @(negedge clk); #2;
        check(buf_empty === 1'b0, "R9 buf_empty while queued", int'(buf_empty), 0);
        wait_idle();

        // R12: format changed mid-frame does not alter it
        set_fmt(2'b11, 1'b0, 1'b1, 1'b0);
        send(8'h81, 0, "R12 format held for frame");
        wait_busy();
        set_fmt(2'b00, 1'b1, 1'b0, 1'b1);
        wait_idle();

        // R11: reset mid-frame with a pending character
        set_fmt(2'b11, 1'b0, 1'b1, 1'b0);
        send(8'h0F, 0, "R11 abandoned");
        wait_busy();
        send(8'hF0, 0, "R11 pending");
        for (int i = 0; i < 60; i++) @(negedge clk);
        mr = 1'b1;
        exp_q.delete();
        @(negedge clk); #2;
        check(txd === 1'b1, "R11 txd after mid-frame reset", int'(txd), 1);
        check(buf_empty === 1'b1, "R11 buf_empty after reset", int'(buf_empty), 1);
        check(tx_empty === 1'b0, "R11 tx_empty in reset", int'(tx_empty), 0);
        @(negedge clk); @(negedge clk);
        mr = 1'b0;
        for (int i = 0; i < 700; i++) @(negedge clk);
        #2;
        check(tx_empty === 1'b1 && txd === 1'b1, "R11 no leftover frame",
              int'({tx_empty, txd}), 3);

        // recovery frame
        set_fmt(2'b01, 1'b0, 1'b0, 1'b1);
        send(8'h1D, 0, "R5 frame after reset");
        wait_idle();
        check(exp_q.size() == 0, "R5 all frames seen", exp_q.size(), 0);

        finish_run();
    end
endmodule